// File: doc/BRIEF.md
# Flash Program Completion Poller

This block sits on the host side of a parallel NOR flash link. Once the host has sent a program or buffered-program command, the poller takes over and decides when that operation has ended and how. A single start pulse hands it three things: the address to watch, the bit 7 value that was actually written there, and a flag that marks a buffered program. For a buffered program the address must be the last word that was loaded into the write buffer. The poller then sends status reads to that address over a simple request/response port until it can report a verdict.

The main check is data polling on bit 7. While the device is still busy it returns the complement of the written bit, and once the write has finished it returns the true bit. The device signals a timing-limit overrun by setting status bit 5. In buffered mode it signals an aborted buffer write by setting bit 1. Either flag may show up just as the write completes, so the poller does not trust a flag at once: it reads bit 7 one more time. A match on that second read still counts as success. A host-side limit on the number of reads also ends a poll that never converges.

Top module: `flash_done_poller`

## Requirements
- R1: During reset and in the first cycle after it, `busy`, `rd_req` and `done_valid` are all 0.
- R2: If `start_valid` is seen at a rising edge while the block is idle, the block latches the address, the expected bit and the mode, and raises `busy`. It also drives `rd_req` high for exactly one cycle, with `rd_addr` equal to the latched address. Each further request is also a one-cycle pulse. No new request is issued until `rd_ack` has returned the data of the previous one.
- R3: If a returned status byte has bit 7 equal to the expected bit, the block ends with result `2'b00` (success), whatever bits 5 and 1 hold. The ending is a one-cycle `done_valid` pulse in the cycle after `rd_ack`, and in that same cycle `busy` falls.
- R4: If bit 7 differs from the expected bit and neither flag applies, the block issues another read to the same address.
- R5: If bit 7 differs and bit 5 is set, the block issues exactly one confirmation read. A bit 7 match on that read ends with success.
- R6: If the confirmation read after a bit 5 flag still mismatches on bit 7, the result is `2'b01` (timeout).
- R7: In buffered mode, a bit 7 mismatch with bit 1 set causes one confirmation read. If that read still mismatches, the result is `2'b10` (abort).
- R8: Outside buffered mode, bit 1 has no effect, and a mismatch with only bit 1 set is treated as an ordinary in-progress read.
- R9: If a mismatching byte has both bit 5 and bit 1 set in buffered mode, a failed confirmation reports timeout (`2'b01`) and not abort.
- R10: If `MAX_POLLS` consecutive in-progress reads arrive with neither flag set, the block ends with timeout (`2'b01`) and issues no further read. Confirmation reads do not count toward this limit.
- R11: A `start_valid` that arrives while `busy` is high is ignored. The address and the outcome of the running operation stay unchanged.
- R12: An `rd_ack` that arrives when no read is outstanding is ignored and produces no `done_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Start a poll (only taken while idle) |
| start_addr | input | ADDR_W | Address to poll |
| start_d7 | input | 1 | True value of bit 7 that was written |
| start_buffered | input | 1 | 1: buffered program, so bit 1 is read as abort |
| busy | output | 1 | An operation is being polled |
| rd_req | output | 1 | One-cycle status read request |
| rd_addr | output | ADDR_W | Address of the status read |
| rd_ack | input | 1 | Status data valid this cycle |
| rd_data | input | STAT_W | Status byte returned |
| done_valid | output | 1 | One-cycle end-of-operation pulse |
| done_result | output | 2 | 00 success, 01 timeout, 10 abort |

## Verification
The assertions check on every cycle that requests and completions are single-cycle pulses, that no completion arrives while busy, and that the polled address holds steady through an operation even when a stray start comes in. They also check that a stray acknowledge in idle yields nothing and that the read counter stays below its limit. Only the bench scenarios show the decision logic. That covers how bit 7, bit 5 and bit 1 combine on the first read and on the confirmation read, the timeout-over-abort priority, bit 1 being ignored outside buffered mode, and the exact read count at which the host-side limit fires.

// File: rtl/fdp_pkg.sv
package fdp_pkg;

  typedef enum logic [1:0] {
    RES_OK      = 2'b00,
    RES_TIMEOUT = 2'b01,
    RES_ABORT   = 2'b10
  } fdp_result_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } fdp_state_e;

  // Does the polled bit show the written value?
  function automatic logic poll_match(input logic polled_bit, input logic expected_bit);
    return polled_bit == expected_bit;
  endfunction

  // Is a failure flag active? Abort only counts in buffered mode.
  function automatic logic flag_seen(input logic limit_bit, input logic abort_bit,
                                     input logic buffered);
    return limit_bit | (buffered & abort_bit);
  endfunction

  // Failure cause to report; the limit flag wins over abort.
  function automatic fdp_result_e flag_cause(input logic limit_bit);
    return limit_bit ? RES_TIMEOUT : RES_ABORT;
  endfunction

endpackage

// File: rtl/fdp_status_judge.sv
module fdp_status_judge
  import fdp_pkg::*;
#(
  parameter int STAT_W    = 8,
  parameter int POLL_BIT  = 7,
  parameter int LIMIT_BIT = 5,
  parameter int ABORT_BIT = 1
) (
  input  logic [STAT_W-1:0] status,
  input  logic              expected_bit,
  input  logic              buffered,
  output logic              match_o,
  output logic              flag_o,
  output fdp_result_e       cause_o
);

  always_comb begin
    match_o = poll_match(status[POLL_BIT], expected_bit);
    flag_o  = flag_seen(status[LIMIT_BIT], status[ABORT_BIT], buffered);
    cause_o = flag_cause(status[LIMIT_BIT]);
  end

endmodule

// File: rtl/fdp_poll_watchdog.sv
module fdp_poll_watchdog #(
  parameter int MAX_POLLS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic count_en,
  output logic expired
);

  localparam int CW = $clog2(MAX_POLLS + 1);
  localparam logic [CW-1:0] LAST = CW'(MAX_POLLS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      cnt_q <= '0;
    end else if (count_en && !expired) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired = count_en && (cnt_q == LAST);

  // R10
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(MAX_POLLS));

endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller
  import fdp_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int STAT_W    = 8,
  parameter int MAX_POLLS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              start_d7,
  input  logic              start_buffered,
  output logic              busy,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ack,
  input  logic [STAT_W-1:0] rd_data,
  output logic              done_valid,
  output logic [1:0]        done_result
);

  fdp_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic              exp_q, buf_q, confirm_q;
  fdp_result_e       cause_q, result_q;
  logic              done_q;

  // Named internal events
  logic        accept, read_back, match, flag, poll_again, expired;
  fdp_result_e cause_now;

  assign accept     = (state_q == ST_IDLE) && start_valid;
  assign read_back  = (state_q == ST_WAIT) && rd_ack;
  assign poll_again = read_back && !confirm_q && !match && !flag;

  fdp_status_judge #(
    .STAT_W(STAT_W), .POLL_BIT(7), .LIMIT_BIT(5), .ABORT_BIT(1)
  ) u_judge (
    .status      (rd_data),
    .expected_bit(exp_q),
    .buffered    (buf_q),
    .match_o     (match),
    .flag_o      (flag),
    .cause_o     (cause_now)
  );

  fdp_poll_watchdog #(.MAX_POLLS(MAX_POLLS)) u_wdog (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (accept),
    .count_en(poll_again),
    .expired (expired)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      addr_q    <= '0;
      exp_q     <= 1'b0;
      buf_q     <= 1'b0;
      confirm_q <= 1'b0;
      cause_q   <= RES_OK;
      result_q  <= RES_OK;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          addr_q    <= start_addr;
          exp_q     <= start_d7;
          buf_q     <= start_buffered;
          confirm_q <= 1'b0;
          state_q   <= ST_ISSUE;
        end
        ST_ISSUE: state_q <= ST_WAIT;
        ST_WAIT: if (read_back) begin
          if (match) begin
            done_q <= 1'b1; result_q <= RES_OK; state_q <= ST_IDLE;
          end else if (confirm_q) begin
            done_q <= 1'b1; result_q <= cause_q; state_q <= ST_IDLE;
          end else if (flag) begin
            confirm_q <= 1'b1; cause_q <= cause_now; state_q <= ST_ISSUE;
          end else if (expired) begin
            done_q <= 1'b1; result_q <= RES_TIMEOUT; state_q <= ST_IDLE;
          end else begin
            state_q <= ST_ISSUE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy        = (state_q != ST_IDLE);
  assign rd_req      = (state_q == ST_ISSUE);
  assign rd_addr     = addr_q;
  assign done_valid  = done_q;
  assign done_result = result_q;

  // R2
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(rd_addr));

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid);

  // R3
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> !busy && !rd_req);

  // R11
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_valid) |=> $stable(rd_addr));

  // R12
  stray_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack && !busy) |=> !done_valid);

endmodule

// File: tb/flash_done_poller_tb.sv
module flash_done_poller_tb;

  localparam int AW   = 16;
  localparam int SW   = 8;
  localparam int MAXP = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_valid = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic          start_d7 = 1'b0;
  logic          start_buffered = 1'b0;
  logic          busy, rd_req, done_valid;
  logic [AW-1:0] rd_addr;
  logic          rd_ack = 1'b0;
  logic [SW-1:0] rd_data = '0;
  logic [1:0]    done_result;

  always #4 clk = ~clk;  // 125 MHz

  flash_done_poller #(.ADDR_W(AW), .STAT_W(SW), .MAX_POLLS(MAXP)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_addr(start_addr),
    .start_d7(start_d7), .start_buffered(start_buffered), .busy(busy),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .done_valid(done_valid), .done_result(done_result)
  );

  int compared = 0;
  int mismatched = 0;
  int reads_total = 0;
  int cycles = 0;
  string cur_req = "R1";
  bit finished = 0;

  logic [7:0] resp_q[$];
  bit inject_stray = 0;

  task automatic check(input string req, input longint act, input longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model, evaluated at every rising edge
  int         m_phase = 0;  // 0 idle, 1 request, 2 awaiting data
  bit         m_done = 0, m_conf = 0, m_d7 = 0, m_buf = 0;
  int         m_res = 0, m_reason = 0, m_polls = 0;
  logic [AW-1:0] m_addr = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_done = 0; m_res = 0; m_polls = 0; m_conf = 0;
    end else begin
      m_done = 0;
      if (m_phase == 0) begin
        if (start_valid) begin
          m_addr = start_addr; m_d7 = start_d7; m_buf = start_buffered;
          m_polls = 0; m_conf = 0; m_phase = 1;
        end
      end else if (m_phase == 1) begin
        m_phase = 2;
      end else if (rd_ack) begin
        if (rd_data[7] == m_d7) begin
          m_done = 1; m_res = 0; m_phase = 0;
        end else if (m_conf) begin
          m_done = 1; m_res = m_reason; m_phase = 0;
        end else if (rd_data[5]) begin
          m_conf = 1; m_reason = 1; m_phase = 1;
        end else if (m_buf && rd_data[1]) begin
          m_conf = 1; m_reason = 2; m_phase = 1;
        end else begin
          m_polls++;
          if (m_polls >= MAXP) begin m_done = 1; m_res = 1; m_phase = 0; end
          else m_phase = 1;
        end
      end
    end
  end

  // Per-cycle comparison, device responder and watchdog (falling edge)
  int lat = -1;
  always @(negedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      mismatched++; compared++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
    if (rst_n) begin
      check({cur_req, " busy"}, busy, m_phase != 0);
      check({cur_req, " rd_req"}, rd_req, m_phase == 1);
      check({cur_req, " done_valid"}, done_valid, m_done);
      if (rd_req) check({cur_req, " rd_addr"}, rd_addr, m_addr);
      if (done_valid) check({cur_req, " done_result"}, done_result, m_res);
    end
    if (rd_req) reads_total++;
    // responder: data returned two falling edges after the request is seen
    rd_ack = 1'b0;
    if (inject_stray) begin
      rd_ack = 1'b1; rd_data = 8'h80; inject_stray = 0;
    end else if (lat == 0) begin
      rd_ack = 1'b1;
      rd_data = (resp_q.size() > 0) ? resp_q.pop_front() : 8'h00;
      lat = -1;
    end else if (lat > 0) begin
      lat--;
    end
    if (rd_req) lat = 1;
  end

  task automatic run_op(input string tag, input logic [AW-1:0] a, input bit d7,
                        input bit bm, input int exp_res, input int exp_reads,
                        input bit intrude);
    int r0;
    int waited;
    cur_req = tag;
    r0 = reads_total;
    @(negedge clk);
    start_valid = 1; start_addr = a; start_d7 = d7; start_buffered = bm;
    @(negedge clk);
    start_valid = 0;
    if (intrude) begin
      start_valid = 1; start_addr = ~a; start_d7 = ~d7; start_buffered = ~bm;
      repeat (3) @(negedge clk);
      start_valid = 0;
    end
    waited = 0;
    while (!done_valid && waited < 200) begin
      @(negedge clk); waited++;
    end
    check({tag, " completion seen"}, done_valid, 1);
    check({tag, " result"}, done_result, exp_res);
    check({tag, " read count"}, reads_total - r0, exp_reads);
    @(negedge clk);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 busy in reset", busy, 0);
    check("R1 rd_req in reset", rd_req, 0);
    check("R1 done in reset", done_valid, 0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 busy after reset", busy, 0);

    // R2 R3: immediate match, address presented
    resp_q = '{8'h80};
    run_op("R3", 16'h1234, 1, 0, 0, 1, 0);
    // R4: two in-progress reads then match (expected bit 0)
    resp_q = '{8'h80, 8'h80, 8'h00};
    run_op("R4", 16'h0AA0, 0, 0, 0, 3, 0);
    // R5: limit flag then confirm matches
    resp_q = '{8'h20, 8'h80};
    run_op("R5", 16'h2000, 1, 0, 0, 2, 0);
    // R6: limit flag, confirm mismatches
    resp_q = '{8'h20, 8'h00};
    run_op("R6", 16'h3001, 1, 0, 1, 2, 0);
    // R7: buffered abort
    resp_q = '{8'h02, 8'h02};
    run_op("R7", 16'h4FFF, 1, 1, 2, 2, 0);
    // R8: bit 1 ignored outside buffered mode
    resp_q = '{8'h02, 8'h80};
    run_op("R8", 16'h5555, 1, 0, 0, 2, 0);
    // R9: both flags in buffered mode -> timeout
    resp_q = '{8'hA2, 8'hA2};
    run_op("R9", 16'h6006, 0, 1, 1, 2, 0);
    // R3: match wins even with flags set
    resp_q = '{8'hA2};
    run_op("R3", 16'h6116, 1, 1, 0, 1, 0);
    // R10: host-side limit
    resp_q = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h80};
    run_op("R10", 16'h7007, 1, 0, 1, MAXP, 0);
    resp_q.delete();
    // R10: confirmation read does not count toward the limit
    resp_q = '{8'h00, 8'h00, 8'h00, 8'h20, 8'h80};
    run_op("R10", 16'h7117, 1, 0, 0, 5, 0);
    // R11: start while busy ignored
    resp_q = '{8'h00, 8'h00, 8'h80};
    run_op("R11", 16'h8008, 1, 0, 0, 3, 1);
    // R12: stray acknowledge while idle
    cur_req = "R12";
    @(negedge clk);
    inject_stray = 1;
    repeat (4) begin
      @(negedge clk);
      check("R12 no done after stray ack", done_valid, 0);
      check("R12 stays idle", busy, 0);
    end
    resp_q = '{8'h00, 8'h80};
    run_op("R12", 16'h9009, 1, 0, 0, 2, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule